// File: doc/BRIEF.md
# External Bus Read/Write Strobe Generator

This block turns one internal request for an external bus access into active-low read and write strobes on three shared output pins. A request gives the direction, the size (byte or word), address bit 0, and whether the target area is 8 bits or 16 bits wide. The strobes are registered. They show the request one clock after it is accepted, and they return to the inactive level when no request is accepted.

The block has two strobe encodings and selects one at run time.
- The **shared-write scheme** drives a read strobe on pin 0, a common write strobe on pin 1, and a high-byte enable on pin 2.
- The **split-write scheme** drives a read strobe on pin 0, a low-byte write strobe on pin 1, and a high-byte write strobe on pin 2.

A bit in a mode register selects the scheme. The mode register sits behind a protect register: a write to the mode register is accepted only while the unlock bit is set, and that unlock bit clears itself after the write lands. Accesses to 8-bit areas always use the shared-write scheme. A word request at an odd address is reported as misaligned, and no strobe is driven for it. A request that arrives in the same cycle as a mode-register write is stalled for that cycle, so the next access already uses the new scheme.

Top module: `bus_strobe_gen`

## Requirements
- R1: After reset, all three strobes are high, `acc_misalign` is 0, and both the mode register and the protect register read back as 0.
- R2: In a cycle with no accepted request, all strobes are high and `acc_misalign` is 0 after the next clock edge.
- R3: An accepted request changes the strobe pins only at the next rising clock edge. The pins stay unchanged in the cycle in which the request is presented.
- R4: Shared-write scheme (mode bit 2 = 0) on a 16-bit area:
  - A read drives pin 0 low and pin 1 high. A write drives pin 0 high and pin 1 low.
  - Pin 2 is low for an odd byte (A0=1) and for a word. It is high for an even byte.
- R5: Split-write scheme (mode bit 2 = 1) on a 16-bit area: every read drives pin 0 low and pins 1 and 2 high, whatever the size and A0.
- R6: Split-write scheme on a 16-bit area, writes. Pin 0 stays high in every case.
  - An even byte drives only pin 1 low.
  - An odd byte drives only pin 2 low.
  - A word drives pins 1 and 2 low.
- R7: A request with `acc_narrow`=1 uses the shared-write encoding whatever the mode bit is, and pin 2 stays high.
- R8: Bit 2 of the mode register (`cfg_sel`=1) selects the scheme. A write to the mode register changes it only while bit 1 of the protect register (`cfg_sel`=0) is 1. Otherwise the write is ignored.
- R9: A mode-register write that is accepted clears bit 1 of the protect register.
- R10: A word request with A0=1 sets `acc_misalign` high for one cycle after the next edge and leaves all strobes high.
- R11: While `cfg_wr_en`=1 and `cfg_sel`=1:
  - A request raises `acc_stall` and is not performed; the strobes stay high.
  - The same request presented in the following cycle uses the newly written mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 protect, 1 mode |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Read-back of the selected register |
| acc_req | input | 1 | Access request for this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_word | input | 1 | 1 word, 0 byte |
| acc_a0 | input | 1 | Address bit 0 |
| acc_narrow | input | 1 | Target area is 8 bits wide |
| acc_stall | output | 1 | Request held off by a mode-register write |
| strobe_rd_n | output | 1 | Pin 0: read strobe |
| strobe_w0_n | output | 1 | Pin 1: shared write strobe or low-byte write strobe |
| strobe_w1_n | output | 1 | Pin 2: high-byte enable or high-byte write strobe |
| acc_misalign | output | 1 | Word access at an odd address |

## Verification
A vector table runs every combination of direction, size and A0 under both schemes on 16-bit areas. It separates the high-byte-enable behaviour from the high-byte-write behaviour, because an odd-byte write is the one pattern where pins 1 and 2 differ between the schemes. The same table repeats byte accesses on 8-bit areas with the split-write scheme selected, which shows that the fallback to the shared-write scheme is forced. It also includes misaligned word requests in both schemes.

Directed sequences cover the remaining behaviour:
- the one-cycle latency;
- a mode write colliding with a request;
- a locked mode write, checked both by read-back and by the strobes of the next access.

// File: rtl/bus_strobe_pkg.sv
// Package: shared types for the external bus strobe generator.
// Assumes pin 0 is the read strobe and pins 1 and 2 carry the
// scheme-dependent write or byte-enable strobes.
package bus_strobe_pkg;

    // Strobe selection scheme held in the mode register.
    typedef enum logic {
        SCHEME_SHARED = 1'b0,
        SCHEME_SPLIT  = 1'b1
    } scheme_e;

    // Register select encoding on the configuration port.
    typedef enum logic {
        CFG_PROTECT = 1'b0,
        CFG_MODE    = 1'b1
    } cfg_sel_e;

    // Three active-low strobe pins.
    typedef struct packed {
        logic rd_n;
        logic w0_n;
        logic w1_n;
    } strobe_t;

    // Attributes of one access request.
    typedef struct packed {
        logic write;
        logic word;
        logic a0;
        logic narrow;
    } acc_attr_t;

    localparam strobe_t STROBE_IDLE = '{rd_n: 1'b1, w0_n: 1'b1, w1_n: 1'b1};

endpackage

// File: rtl/strobe_cfg_regs.sv
// Module: protect and mode registers with write-unlock handling.
// A mode write lands only while the unlock bit is set; landing clears
// that bit. Assumes at most one register write per cycle.
module strobe_cfg_regs
    import bus_strobe_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MODE_BIT   = 2,
    parameter int UNLOCK_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] prot_q,
    output logic [DATA_W-1:0] mode_q,
    output scheme_e           scheme,
    output logic              mode_wr_pend
);

    logic prot_hit;
    logic mode_ok;

    // Decode which register a write addresses and whether it may land.
    always_comb begin
        prot_hit     = wr_en && (sel == CFG_PROTECT);
        mode_wr_pend = wr_en && (sel == CFG_MODE);
        mode_ok      = mode_wr_pend && prot_q[UNLOCK_BIT];
    end

    // Protect register: loaded by software, unlock bit consumed by a mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= '0;
        end else if (prot_hit) begin
            prot_q <= wdata;
        end else if (mode_ok) begin
            prot_q[UNLOCK_BIT] <= 1'b0;
        end
    end

    // Mode register: updated only through an unlocked write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_ok) begin
            mode_q <= wdata;
        end
    end

    // Read-back mux and scheme extraction.
    always_comb begin
        rdata  = (sel == CFG_MODE) ? mode_q : prot_q;
        scheme = scheme_e'(mode_q[MODE_BIT]);
    end

endmodule

// File: rtl/strobe_encoder.sv
// Module: combinational map from access attributes and scheme to the
// three strobe levels. Narrow areas always use the shared scheme.
// A word at an odd address yields idle strobes and a misalign flag.
module strobe_encoder
    import bus_strobe_pkg::*;
(
    input  acc_attr_t attr,
    input  scheme_e   scheme,
    output strobe_t   strobe,
    output logic      misalign
);

    // Select the strobe pattern for this request.
    always_comb begin
        strobe   = STROBE_IDLE;
        misalign = attr.word && attr.a0;
        if (!misalign) begin
            if (attr.narrow || scheme == SCHEME_SHARED) begin
                strobe.rd_n = attr.write;
                strobe.w0_n = !attr.write;
                strobe.w1_n = attr.narrow ? 1'b1 : !(attr.word || attr.a0);
            end else if (!attr.write) begin
                strobe.rd_n = 1'b0;
            end else begin
                strobe.w0_n = !(attr.word || !attr.a0);
                strobe.w1_n = !(attr.word || attr.a0);
            end
        end
    end

endmodule

// File: rtl/strobe_out_reg.sv
// Module: output register stage. Loads the encoded strobes when a
// request fires, otherwise returns every strobe to inactive.
module strobe_out_reg
    import bus_strobe_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fire,
    input  strobe_t strobe_d,
    input  logic    misalign_d,
    output strobe_t strobe_q,
    output logic    misalign_q
);

    // Register strobes and misalign flag once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q   <= STROBE_IDLE;
            misalign_q <= 1'b0;
        end else if (fire) begin
            strobe_q   <= strobe_d;
            misalign_q <= misalign_d;
        end else begin
            strobe_q   <= STROBE_IDLE;
            misalign_q <= 1'b0;
        end
    end

endmodule

// File: rtl/bus_strobe_gen.sv
// Module: top of the external bus strobe generator. Accepts one
// request per cycle, stalls it while a mode write is in flight, and
// drives registered active-low strobes one clock later.
module bus_strobe_gen
    import bus_strobe_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MODE_BIT   = 2,
    parameter int UNLOCK_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              acc_req,
    input  logic              acc_write,
    input  logic              acc_word,
    input  logic              acc_a0,
    input  logic              acc_narrow,
    output logic              acc_stall,
    output logic              strobe_rd_n,
    output logic              strobe_w0_n,
    output logic              strobe_w1_n,
    output logic              acc_misalign
);

    logic [DATA_W-1:0] cfg_prot_q;
    logic [DATA_W-1:0] cfg_mode_q;
    scheme_e           scheme;
    logic              mode_wr_pend;
    acc_attr_t         attr;
    strobe_t           strobe_d;
    strobe_t           strobe_q;
    logic              misalign_d;
    logic              fire;

    strobe_cfg_regs #(
        .DATA_W    (DATA_W),
        .MODE_BIT  (MODE_BIT),
        .UNLOCK_BIT(UNLOCK_BIT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr_en),
        .sel         (cfg_sel),
        .wdata       (cfg_wdata),
        .rdata       (cfg_rdata),
        .prot_q      (cfg_prot_q),
        .mode_q      (cfg_mode_q),
        .scheme      (scheme),
        .mode_wr_pend(mode_wr_pend)
    );

    // Gather request attributes and decide whether the request fires.
    always_comb begin
        attr      = '{write: acc_write, word: acc_word, a0: acc_a0, narrow: acc_narrow};
        acc_stall = acc_req && mode_wr_pend;
        fire      = acc_req && !mode_wr_pend;
    end

    strobe_encoder u_enc (
        .attr    (attr),
        .scheme  (scheme),
        .strobe  (strobe_d),
        .misalign(misalign_d)
    );

    strobe_out_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .strobe_d  (strobe_d),
        .misalign_d(misalign_d),
        .strobe_q  (strobe_q),
        .misalign_q(acc_misalign)
    );

    // Break the registered strobe struct out onto the pins.
    always_comb begin
        strobe_rd_n = strobe_q.rd_n;
        strobe_w0_n = strobe_q.w0_n;
        strobe_w1_n = strobe_q.w1_n;
    end

endmodule

// File: rtl/bus_strobe_gen_chk.sv
// Module: temporal checks on the strobe generator, bound to the top.
// Assumes the bound instance exposes the register contents.
module bus_strobe_gen_chk #(
    parameter int DATA_W     = 8,
    parameter int UNLOCK_BIT = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic              cfg_sel,
    input logic              acc_req,
    input logic              acc_stall,
    input logic              acc_word,
    input logic              acc_a0,
    input logic              acc_narrow,
    input logic              strobe_rd_n,
    input logic              strobe_w0_n,
    input logic              strobe_w1_n,
    input logic              acc_misalign,
    input logic [DATA_W-1:0] prot_q,
    input logic [DATA_W-1:0] mode_q
);

    // R2
    idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> (strobe_rd_n && strobe_w0_n && strobe_w1_n && !acc_misalign));

    // R11
    stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_stall) |=> (strobe_rd_n && strobe_w0_n && strobe_w1_n && !acc_misalign));

    // R10
    misalign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_stall && acc_word && acc_a0)
        |=> (acc_misalign && strobe_rd_n && strobe_w0_n && strobe_w1_n));

    // R8
    locked_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_sel && !prot_q[UNLOCK_BIT]) |=> $stable(mode_q));

    // R9
    unlock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_sel && prot_q[UNLOCK_BIT]) |=> !prot_q[UNLOCK_BIT]);

    // R7
    narrow_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_stall && acc_narrow) |=> strobe_w1_n);

    // R6
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_rd_n |-> strobe_w0_n);

endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(
    .DATA_W    (DATA_W),
    .UNLOCK_BIT(UNLOCK_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_sel     (cfg_sel),
    .acc_req     (acc_req),
    .acc_stall   (acc_stall),
    .acc_word    (acc_word),
    .acc_a0      (acc_a0),
    .acc_narrow  (acc_narrow),
    .strobe_rd_n (strobe_rd_n),
    .strobe_w0_n (strobe_w0_n),
    .strobe_w1_n (strobe_w1_n),
    .acc_misalign(acc_misalign),
    .prot_q      (cfg_prot_q),
    .mode_q      (cfg_mode_q)
);

// File: tb/bus_strobe_gen_bench.sv
`timescale 1ns/1ps
// Bench: vector table over both schemes, then directed tests.
module bus_strobe_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       acc_req = 1'b0;
    logic       acc_write = 1'b0;
    logic       acc_word = 1'b0;
    logic       acc_a0 = 1'b0;
    logic       acc_narrow = 1'b0;
    logic       acc_stall;
    logic       strobe_rd_n;
    logic       strobe_w0_n;
    logic       strobe_w1_n;
    logic       acc_misalign;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    bus_strobe_gen u_bus_strobe_gen (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_req(acc_req), .acc_write(acc_write), .acc_word(acc_word), .acc_a0(acc_a0),
        .acc_narrow(acc_narrow), .acc_stall(acc_stall),
        .strobe_rd_n(strobe_rd_n), .strobe_w0_n(strobe_w0_n), .strobe_w1_n(strobe_w1_n),
        .acc_misalign(acc_misalign)
    );

    // Vector: {mode, narrow, write, word, a0, rd_n, w0_n, w1_n, misalign}
    localparam int NVEC = 18;
    localparam logic [8:0] VECS [NVEC] = '{
        9'b0_0_0_0_0_0110, 9'b0_0_0_0_1_0100, 9'b0_0_0_1_0_0100,
        9'b0_0_1_0_0_1010, 9'b0_0_1_0_1_1000, 9'b0_0_1_1_0_1000,
        9'b0_1_1_0_1_1010, 9'b0_0_1_1_1_1111,
        9'b1_0_0_0_0_0110, 9'b1_0_0_0_1_0110, 9'b1_0_0_1_0_0110,
        9'b1_0_1_0_0_1010, 9'b1_0_1_0_1_1100, 9'b1_0_1_1_0_1000,
        9'b1_1_0_0_1_0110, 9'b1_1_1_0_1_1010, 9'b1_1_1_0_0_1010,
        9'b1_0_0_1_1_1111
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pins();
        return {4'b0, strobe_rd_n, strobe_w0_n, strobe_w1_n, acc_misalign};
    endfunction

    task automatic cfg_write(input logic sel, input logic [7:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic sel, output logic [7:0] data);
        @(negedge clk);
        cfg_sel = sel;
        #1 data = cfg_rdata;
    endtask

    task automatic set_mode(input logic m);
        cfg_write(1'b0, 8'h02);
        cfg_write(1'b1, m ? 8'h04 : 8'h00);
    endtask

    // Present one request for a cycle and return pins seen after the edge.
    task automatic access(input logic w, input logic wd, input logic a, input logic n,
                          output logic [7:0] seen);
        @(negedge clk);
        acc_req = 1'b1; acc_write = w; acc_word = wd; acc_a0 = a; acc_narrow = n;
        @(negedge clk);
        seen = pins();
        acc_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       cur_mode;
        string      tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 pins", pins(), 8'h0E);
        cfg_read(1'b0, rd); check("R1 protect", rd, 8'h00);
        cfg_read(1'b1, rd); check("R1 mode", rd, 8'h00);

        cur_mode = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i][8] != cur_mode) begin
                set_mode(VECS[i][8]);
                cur_mode = VECS[i][8];
            end
            access(VECS[i][6], VECS[i][5], VECS[i][4], VECS[i][7], rd);
            if (VECS[i][0])       tag = "R10 misalign";
            else if (VECS[i][7])  tag = "R7 narrow";
            else if (!VECS[i][8]) tag = "R4 shared";
            else if (VECS[i][6])  tag = "R6 split write";
            else                  tag = "R5 split read";
            check(tag, rd, {4'b0, VECS[i][3:0]});
            @(negedge clk);
            check("R2 idle after access", pins(), 8'h0E);
        end

        // R3: no change before the edge, result after it
        set_mode(1'b0);
        @(negedge clk);
        acc_req = 1'b1; acc_write = 1'b0; acc_word = 1'b1; acc_a0 = 1'b0; acc_narrow = 1'b0;
        #1 check("R3 before edge", pins(), 8'h0E);
        @(negedge clk);
        check("R3 after edge", pins(), 8'h04);
        acc_req = 1'b0;

        // R11: request colliding with an unlocked mode write
        cfg_write(1'b0, 8'h02);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h04;
        acc_req = 1'b1; acc_write = 1'b1; acc_word = 1'b0; acc_a0 = 1'b1; acc_narrow = 1'b0;
        #1 check("R11 stall raised", {7'b0, acc_stall}, 8'h01);
        @(negedge clk);
        check("R11 stalled pins idle", pins(), 8'h0E);
        cfg_wr_en = 1'b0;
        #1 check("R11 stall released", {7'b0, acc_stall}, 8'h00);
        @(negedge clk);
        check("R11 new scheme used", pins(), 8'h0C);
        acc_req = 1'b0;

        // R9: unlock bit consumed
        cfg_read(1'b0, rd); check("R9 protect cleared", rd, 8'h00);
        // R8: locked write ignored
        cfg_write(1'b1, 8'h00);
        cfg_read(1'b1, rd); check("R8 mode kept", rd, 8'h04);
        access(1'b1, 1'b0, 1'b1, 1'b0, rd);
        check("R8 scheme kept", rd, 8'h0C);
        // R8: unlocked write back to shared scheme
        set_mode(1'b0);
        access(1'b1, 1'b0, 1'b1, 1'b0, rd);
        check("R8 shared restored", rd, 8'h08);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule